// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory instruction into the stream of word addresses its elements occupy. A single-cycle start pulse captures a base word address, an element count, a signed stride and an addressing mode. The block then offers one address per cycle on a valid/ready output. A downstream memory port takes each address when it is ready. One pulse on `done_o` marks the end of the sequence. The same address stream serves a gather (load) and a scatter (store), so the block does not know the direction of the transfer.

Three addressing styles share one sequencer. In sequential mode the elements sit in consecutive words. In strided mode a fixed signed number of words separates neighbouring elements. In indexed mode each element's address is the base plus a signed offset from a separate index stream, which has its own valid/ready pair. That stream stands in for the index vector register, and each offset works like a register-indirect access for one element. The block moves no data and arbitrates no memory.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is held, and directly after it, `addr_valid_o`, `idx_ready_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: With `mode_i` = 2'b00 (sequential) and count N > 0, the block issues exactly N addresses, base, base+1, ..., base+N-1, and the sum wraps modulo 2^32.
- R3: With `mode_i` = 2'b01 (strided), element i gets the address base + i * stride. The stride is a signed 16-bit word offset, and the sum wraps modulo 2^32.
- R4: With `mode_i` = 2'b10 (indexed), element i gets the address base plus the sign-extended 16-bit offset i taken from the index port. An address appears only after its offset has been accepted. Exactly N offsets are accepted, and `idx_ready_o` stays low in every other mode and once N offsets have been taken.
- R5: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `addr_valid_o` hold their values. The sequence advances only on a cycle where valid and ready are both high.
- R6: `done_o` is high for exactly one cycle, the cycle after the handshake of the last address.
- R7: A start with count zero and a legal mode issues no address and raises `done_o` for one cycle, in the cycle after the start.
- R8: A start with `mode_i` = 2'b11 issues no address and does not raise `done_o`. It raises `err_o` for one cycle, in the cycle after the start.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running sequence goes on with its original base, stride, mode and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to begin a sequence |
| mode_i | input | 2 | 00 sequential, 01 strided, 10 indexed, 11 illegal |
| base_i | input | 32 | Base word address |
| stride_i | input | 16 | Signed stride in words |
| count_i | input | 16 | Number of elements |
| addr_o | output | 32 | Current element word address |
| addr_valid_o | output | 1 | `addr_o` holds a valid address |
| addr_ready_i | input | 1 | Consumer takes `addr_o` this cycle |
| idx_data_i | input | 16 | Signed per-element offset |
| idx_valid_i | input | 1 | `idx_data_i` is valid |
| idx_ready_o | output | 1 | Block accepts an offset this cycle |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | One-cycle illegal-mode pulse |

## Verification
The embedded properties assume that the consumer does not rely on `addr_valid_o` being withdrawn once asserted, and that the start parameters matter only in the cycle of an accepted start. The bench changes every input only just after a rising edge, so each input stays constant across the following edge. The bench keeps start pulses one cycle long and supplies offsets only from a prepared queue. It throttles both handshakes with a pseudo-random pattern, so stalls fall on the first and last elements as well as on the elements in between. A second start is deliberately placed inside a running sequence, and the expected address list is left unchanged for it.

// File: rtl/vag_pkg.sv
package vag_pkg;

   typedef enum logic [1:0] {
      VAG_SEQ    = 2'b00,
      VAG_STRIDE = 2'b01,
      VAG_INDEX  = 2'b10,
      VAG_ILLEGAL = 2'b11
   } vag_mode_e;

endpackage

// File: rtl/vag_seq.sv
module vag_seq
   import vag_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  vag_mode_e        mode_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             fire_i,
   input  logic             idx_take_i,
   output logic             load_o,
   output logic             busy_o,
   output vag_mode_e        mode_o,
   output logic             last_o,
   output logic             idx_pend_o,
   output logic             done_o,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             busy_q;
   vag_mode_e        mode_q;
   logic [CNT_W-1:0] elem_left_q;
   logic [CNT_W-1:0] idx_left_q;
   logic             done_q;
   logic             err_q;

   logic accept;
   logic bad_mode;
   logic empty;

   initial begin
      assert (CNT_W >= 2) else $error("vag_seq: CNT_W must be at least 2");
   end

   assign accept   = start_i && !busy_q;
   assign bad_mode = (mode_i == VAG_ILLEGAL);
   assign empty    = (count_i == '0);
   assign load_o   = accept && !bad_mode && !empty;
   assign last_o   = (elem_left_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         mode_q      <= VAG_SEQ;
         elem_left_q <= '0;
         idx_left_q  <= '0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (bad_mode) begin
               err_q <= 1'b1;
            end else if (empty) begin
               done_q <= 1'b1;
            end else begin
               busy_q      <= 1'b1;
               mode_q      <= mode_i;
               elem_left_q <= count_i;
               idx_left_q  <= (mode_i == VAG_INDEX) ? count_i : '0;
            end
         end else if (busy_q) begin
            if (idx_take_i) begin
               idx_left_q <= idx_left_q - ONE;
            end
            if (fire_i) begin
               elem_left_q <= elem_left_q - ONE;
               if (last_o) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign busy_o     = busy_q;
   assign mode_o     = mode_q;
   assign idx_pend_o = (idx_left_q != '0);
   assign done_o     = done_q;
   assign err_o      = err_q;

   // R6: the final handshake closes the sequence on the next edge
   assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && fire_i && last_o) |=> (done_o && !busy_o));

   // R7: an empty legal request finishes at once
   assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && empty && !bad_mode) |=> (done_o && !busy_o));

   // R8: an illegal mode never starts a sequence
   assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !done_o));

   // R9: a running sequence keeps its mode until its last handshake
   assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !(fire_i && last_o)) |=> (busy_q && $stable(mode_q)));

endmodule

// File: rtl/vag_addr_path.sv
module vag_addr_path
   import vag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  vag_mode_e         mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  stride_i,
   input  logic [OFF_W-1:0]  idx_i,
   input  logic              idx_take_i,
   input  logic              fire_i,
   input  logic              last_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              vld_o
);

   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] stride_ext;
   logic [ADDR_W-1:0] idx_ext;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] step_q;
   logic [ADDR_W-1:0] addr_q;
   logic              vld_q;
   logic              idx_mode_q;

   initial begin
      assert (OFF_W >= 2 && OFF_W <= ADDR_W)
         else $error("vag_addr_path: OFF_W must lie in 2..ADDR_W");
   end

   generate
      if (EXT_W > 0) begin : g_sext
         assign stride_ext = {{EXT_W{stride_i[OFF_W-1]}}, stride_i};
         assign idx_ext    = {{EXT_W{idx_i[OFF_W-1]}}, idx_i};
      end else begin : g_same
         assign stride_ext = stride_i;
         assign idx_ext    = idx_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q     <= '0;
         step_q     <= '0;
         addr_q     <= '0;
         vld_q      <= 1'b0;
         idx_mode_q <= 1'b0;
      end else if (load_i) begin
         base_q     <= base_i;
         step_q     <= (mode_i == VAG_STRIDE) ? stride_ext : ADDR_W'(1);
         addr_q     <= base_i;
         idx_mode_q <= (mode_i == VAG_INDEX);
         vld_q      <= (mode_i != VAG_INDEX);
      end else if (idx_mode_q) begin
         if (idx_take_i) begin
            addr_q <= base_q + idx_ext;
            vld_q  <= 1'b1;
         end else if (fire_i) begin
            vld_q <= 1'b0;
         end
      end else if (fire_i) begin
         addr_q <= addr_q + step_q;
         if (last_i) begin
            vld_q <= 1'b0;
         end
      end
   end

   assign addr_o = addr_q;
   assign vld_o  = vld_q;

   // R5: a stalled address is held unchanged
   assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !fire_i) |=> (vld_q && $stable(addr_q)));

   // R3: each accepted non-indexed element moves the address by one step
   assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !idx_mode_q && fire_i && !last_i) |=>
         (addr_q == $past(addr_q) + $past(step_q)));

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
   import vag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  stride_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_valid_o,
   input  logic              addr_ready_i,
   input  logic [OFF_W-1:0]  idx_data_i,
   input  logic              idx_valid_i,
   output logic              idx_ready_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   vag_mode_e mode_in;
   vag_mode_e mode_run;
   logic      fire;
   logic      idx_take;
   logic      load;
   logic      last;
   logic      idx_pend;
   logic      vld;

   assign mode_in  = vag_mode_e'(mode_i);
   assign fire     = vld && addr_ready_i;
   assign idx_take = idx_valid_i && idx_ready_o;

   assign idx_ready_o = busy_o && (mode_run == VAG_INDEX) && idx_pend &&
                        (!vld || addr_ready_i);

   vag_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_in),
      .count_i    (count_i),
      .fire_i     (fire),
      .idx_take_i (idx_take),
      .load_o     (load),
      .busy_o     (busy_o),
      .mode_o     (mode_run),
      .last_o     (last),
      .idx_pend_o (idx_pend),
      .done_o     (done_o),
      .err_o      (err_o)
   );

   vag_addr_path #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .mode_i     (mode_in),
      .base_i     (base_i),
      .stride_i   (stride_i),
      .idx_i      (idx_data_i),
      .idx_take_i (idx_take),
      .fire_i     (fire),
      .last_i     (last),
      .addr_o     (addr_o),
      .vld_o      (vld)
   );

   assign addr_valid_o = vld;

   // R4: an accepted offset is visible as an address on the next cycle
   assert_idx_emits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idx_take |=> addr_valid_o);

   // R1: nothing is offered while no sequence runs
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!addr_valid_o && !idx_ready_o));

endmodule

// File: tb/tb_vec_addr_gen.sv
`timescale 1ns/1ps
module tb_vec_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic [31:0] base_i = '0;
   logic [15:0] stride_i = '0;
   logic [15:0] count_i = '0;
   logic [31:0] addr_o;
   logic        addr_valid_o;
   logic        addr_ready_i = 1'b1;
   logic [15:0] idx_data_i = '0;
   logic        idx_valid_i = 1'b0;
   logic        idx_ready_o;
   logic        busy_o;
   logic        done_o;
   logic        err_o;

   always #2.5 clk = ~clk;

   vec_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .base_i(base_i), .stride_i(stride_i), .count_i(count_i),
      .addr_o(addr_o), .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
      .idx_data_i(idx_data_i), .idx_valid_i(idx_valid_i), .idx_ready_o(idx_ready_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   int          cyc = 0;
   int          fires = 0;
   int          last_fire_cyc = -10;
   int          s_cyc = 0;
   int          done_cyc = 0;
   int          err_cyc = 0;
   bit          done_seen = 0;
   bit          err_seen = 0;
   bit          bp_en = 0;
   bit          idx_acc = 0;
   bit          prev_stall = 0;
   bit          finished = 0;
   logic [31:0] prev_addr = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic [1:0]  cur_mode = 2'b00;
   string       cur_req = "R2";
   logic [31:0] exp_q[$];
   logic [15:0] idx_q[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (addr_valid_o && addr_ready_i) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_req, " unexpected address"}, addr_o, 32'h0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(addr_o == e, cur_req, addr_o, e);
            end
            last_fire_cyc = cyc;
            fires++;
         end
         if (prev_stall) begin
            chk(addr_valid_o && addr_o == prev_addr, "R5 hold under stall", addr_o, prev_addr);
         end
         prev_stall = addr_valid_o && !addr_ready_i;
         prev_addr  = addr_o;
         if (idx_ready_o && cur_mode != 2'b10) begin
            chk(1'b0, "R4 idx_ready outside indexed mode", 32'(idx_ready_o), 32'h0);
         end
         idx_acc = idx_valid_i && idx_ready_o;
         if (done_o) begin done_seen = 1; done_cyc = cyc; end
         if (err_o)  begin err_seen = 1;  err_cyc = cyc;  end
      end else begin
         idx_acc = 0;
         prev_stall = 0;
      end
   end

   // handshake drivers
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr_ready_i = bp_en ? (lfsr[0] | lfsr[4]) : 1'b1;
      if (idx_acc && idx_q.size() > 0) void'(idx_q.pop_front());
      idx_valid_i = (idx_q.size() > 0) && (bp_en ? (lfsr[7] | lfsr[2]) : 1'b1);
      idx_data_i  = (idx_q.size() > 0) ? idx_q[0] : 16'h0;
   end

   task automatic start_vec(input logic [1:0] m, input logic [31:0] b,
                            input logic [15:0] s, input logic [15:0] n, input string req);
      if (m != 2'b11) begin
         for (int i = 0; i < int'(n); i++) begin
            if (m == 2'b00)      exp_q.push_back(b + 32'(i));
            else if (m == 2'b01) exp_q.push_back(b + sext(s) * 32'(i));
            else                 exp_q.push_back(b + sext(idx_q[i]));
         end
      end
      done_seen = 0;
      err_seen  = 0;
      cur_mode  = m;
      cur_req   = req;
      @(posedge clk); #1;
      start_i = 1'b1; mode_i = m; base_i = b; stride_i = s; count_i = n;
      s_cyc = cyc + 1;
      @(posedge clk); #1;
      start_i = 1'b0;
      stride_i = 16'h5A5A; base_i = 32'hDEAD_0000; count_i = 16'd3;
   endtask

   task automatic wait_vec(input string req);
      while (!done_seen) begin @(negedge clk); #1; end
      chk(exp_q.size() == 0, {req, " R6 all addresses issued"}, 32'(exp_q.size()), 32'h0);
      chk(done_cyc == last_fire_cyc + 1, "R6 done after last handshake",
          32'(done_cyc), 32'(last_fire_cyc + 1));
      @(negedge clk); #1;
      chk(!done_o, "R6 done lasts one cycle", 32'(done_o), 32'h0);
      chk(!idx_ready_o && idx_q.size() == 0, "R4 offsets all consumed",
          32'(idx_q.size()), 32'h0);
   endtask

   task automatic run_vec(input logic [1:0] m, input logic [31:0] b,
                          input logic [15:0] s, input logic [15:0] n, input string req);
      start_vec(m, b, s, n, req);
      wait_vec(req);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int f0;
      repeat (3) @(negedge clk);
      chk(!addr_valid_o && !idx_ready_o && !busy_o && !done_o && !err_o,
          "R1 outputs low in reset", {27'h0, addr_valid_o, idx_ready_o, busy_o, done_o, err_o}, 32'h0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!addr_valid_o && !idx_ready_o && !busy_o && !done_o && !err_o,
          "R1 outputs low after reset", {27'h0, addr_valid_o, idx_ready_o, busy_o, done_o, err_o}, 32'h0);

      run_vec(2'b00, 32'd100, 16'd0, 16'd8, "R2 sequential");
      bp_en = 1;
      run_vec(2'b00, 32'h0000_4000, 16'd0, 16'd12, "R2 sequential stalled");
      run_vec(2'b00, 32'hFFFF_FFFE, 16'd0, 16'd4, "R2 sequential wrap");
      bp_en = 0;
      run_vec(2'b01, 32'd1000, 16'd3, 16'd6, "R3 positive stride");
      run_vec(2'b01, 32'd10, 16'hFFFB, 16'd5, "R3 negative stride wrap");
      bp_en = 1;
      run_vec(2'b01, 32'h8000_0000, 16'h7FFF, 16'd7, "R3 large stride stalled");
      bp_en = 0;
      idx_q = '{16'd5, 16'hFFFE, 16'd100, 16'h7FFF, 16'h8000};
      run_vec(2'b10, 32'h0001_0000, 16'd0, 16'd5, "R4 indexed");
      bp_en = 1;
      idx_q = '{16'd0, 16'd9, 16'hFFFF, 16'd3, 16'd3, 16'h1234, 16'hF000, 16'd1};
      run_vec(2'b10, 32'd20, 16'd0, 16'd8, "R4 indexed stalled");
      bp_en = 0;

      f0 = fires;
      start_vec(2'b01, 32'd500, 16'd2, 16'd0, "R7 zero count");
      repeat (3) begin @(negedge clk); #1; end
      chk(done_seen && done_cyc == s_cyc + 1, "R7 done one cycle after start",
          32'(done_cyc), 32'(s_cyc + 1));
      chk(fires == f0, "R7 no address issued", 32'(fires - f0), 32'h0);

      f0 = fires;
      start_vec(2'b11, 32'd500, 16'd2, 16'd5, "R8 illegal mode");
      repeat (4) begin @(negedge clk); #1; end
      chk(err_seen && err_cyc == s_cyc + 1, "R8 err one cycle after start",
          32'(err_cyc), 32'(s_cyc + 1));
      chk(!done_seen && fires == f0 && !busy_o, "R8 no done no address",
          32'(fires - f0), 32'h0);

      bp_en = 1;
      start_vec(2'b00, 32'd7000, 16'd0, 16'd10, "R9 start while busy");
      @(posedge clk); #1;
      start_i = 1'b1; mode_i = 2'b01; base_i = 32'd1; stride_i = 16'd50; count_i = 16'd2;
      @(posedge clk); #1;
      start_i = 1'b0;
      wait_vec("R9 start while busy");
      bp_en = 0;

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule